// File: doc/BRIEF.md
# Gated One-Shot Pulse Generator

This block produces a single output pulse of a chosen number of clock cycles in answer to a trigger event. Two trigger inputs are provided. One is active low and fires on its falling edge. The other is active high and fires on its rising edge. Each of them acts only while the other is held at its enabling level, so the pair can fire on either edge of a strobe. An active-low clear input overrides everything else. Once a pulse has started it cannot be retriggered.

All three control inputs may be asynchronous to the clock. They pass through a synchronizer, and edges are found by comparing the synchronized sample with the sample from the previous cycle. The pulse length is taken from the `width` input at the moment of the trigger, and later changes to `width` do not affect that pulse. A clear that rises while both trigger inputs sit at their enabling levels also starts a pulse. This happens only if the trigger inputs were first seen disabled and were then brought to their enabling levels while clear was low. A system that needs two channels places two instances.

Top module: `oneshot_pulser`

## Requirements
- R1: After the system reset `rst_n` is released, `pulse_q` is 0 and `pulse_qn` is 1, and nothing starts until a trigger condition arrives.
- R2: A high-to-low change on `trig_fall_n` starts a pulse when `trig_rise` is 1 and `clear_n` is 1. `pulse_q` goes to 1 on the third rising clock edge after the input change, which is SYNC_STAGES+1 edges with the default of 2 synchronizer stages.
- R3: A low-to-high change on `trig_rise` starts a pulse when `trig_fall_n` is 0 and `clear_n` is 1, with the same latency as R2.
- R4: While `trig_fall_n` is held at 1, or while `trig_rise` is held at 0, no activity on the other trigger input starts a pulse.
- R5: A pulse keeps `pulse_q` at 1 for exactly N clock cycles. N is the value on `width` in the cycle the trigger is accepted. Changing `width` during the pulse has no effect, and the largest value (2^WIDTH_W - 1) gives that many cycles.
- R6: Trigger edges that occur while a pulse runs are ignored, including an edge in the final cycle of the pulse. The pulse is neither extended nor restarted, and no second pulse follows.
- R7: `clear_n` at 0 ends a running pulse. `pulse_q` falls on the third rising edge after `clear_n` falls. While `clear_n` stays 0, no trigger edge starts a pulse.
- R8: A rising `clear_n` starts a pulse when `trig_fall_n` is 0 and `trig_rise` is 1, provided that while `clear_n` was low the trigger inputs were first seen disabled (`trig_fall_n` 1 or `trig_rise` 0). If they stay at their enabling levels for the whole low period, the clear release starts nothing.
- R9: A trigger accepted with `width` equal to 0 produces no pulse.
- R10: `pulse_qn` is always the complement of `pulse_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset, used at power-up |
| trig_fall_n | input | 1 | Trigger that fires on its falling edge while `trig_rise` is 1 |
| trig_rise | input | 1 | Trigger that fires on its rising edge while `trig_fall_n` is 0 |
| clear_n | input | 1 | Overriding active-low clear; its rising edge can also start a pulse (R8) |
| width | input | WIDTH_W | Pulse length in clock cycles, captured when a trigger is accepted |
| pulse_q | output | 1 | Pulse output, 1 while a pulse runs |
| pulse_qn | output | 1 | Complement of `pulse_q` |

## Verification
The checker works from the synchronized clear level and the internal start strobe. It assumes that each input level is held across at least one sampling edge, so the synchronizer never drops a change. The bench changes the inputs only at the falling clock edge and holds every value for at least one full cycle, in both the directed phases and the random phase. A cycle-level model in the bench predicts `pulse_q` at every falling edge. The random phase keeps `clear_n` high most of the time so that pulses run to their natural end as well as being cut short.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

   // Sampled control levels; member order matches {clear_n, trig_rise, trig_fall_n}
   typedef struct packed {
      logic clr;
      logic rise_in;
      logic fall_in;
   } lvl_t;

   // Which event started a pulse
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_FALL = 2'd1,
      SRC_RISE = 2'd2,
      SRC_CLR  = 2'd3
   } src_e;

   // Levels that can never form a start edge: clear asserted, triggers in enabling state
   localparam lvl_t LVL_QUIET = '{clr: 1'b0, rise_in: 1'b1, fall_in: 1'b0};

   function automatic logic is_disarmed(input lvl_t v);
      return v.fall_in | ~v.rise_in;
   endfunction

   function automatic logic is_armed(input lvl_t v);
      return ~v.fall_in & v.rise_in;
   endfunction

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
   parameter int          N       = 3,
   parameter int          STAGES  = 2,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);

   logic [N-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/oneshot_trig_gate.sv
module oneshot_trig_gate
   import oneshot_pkg::*;
#(
   parameter bit CLEAR_STARTS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  lvl_t cur,
   input  logic idle,
   output logic go
);

   lvl_t prev;
   logic seen_off;
   logic fall_ev, rise_ev, clr_ev, clr_ok;
   src_e src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev     <= LVL_QUIET;
         seen_off <= 1'b0;
      end else begin
         prev     <= cur;
         seen_off <= cur.clr ? 1'b0 : (seen_off | is_disarmed(cur));
      end
   end

   assign fall_ev = prev.fall_in & ~cur.fall_in;
   assign rise_ev = ~prev.rise_in & cur.rise_in;
   assign clr_ev  = ~prev.clr & cur.clr;

   generate
      if (CLEAR_STARTS) begin : g_clr_start
         assign clr_ok = clr_ev & is_armed(cur) & seen_off;
      end else begin : g_no_clr_start
         assign clr_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      src = SRC_NONE;
      if (idle && cur.clr) begin
         if (fall_ev && cur.rise_in)       src = SRC_FALL;
         else if (rise_ev && !cur.fall_in) src = SRC_RISE;
         else if (clr_ok)                  src = SRC_CLR;
      end
   end

   assign go = (src != SRC_NONE);

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
   parameter int WIDTH_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_ok,
   input  logic               go,
   input  logic [WIDTH_W-1:0] width,
   output logic               q,
   output logic               qn,
   output logic [WIDTH_W-1:0] cnt,
   output logic [WIDTH_W-1:0] lat_w
);

   localparam logic [WIDTH_W-1:0] ONE = WIDTH_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q     <= 1'b0;
         qn    <= 1'b1;
         cnt   <= '0;
         lat_w <= '0;
      end else if (!run_ok) begin
         q   <= 1'b0;
         qn  <= 1'b1;
         cnt <= '0;
      end else if (q) begin
         if (cnt == lat_w) begin
            q   <= 1'b0;
            qn  <= 1'b1;
            cnt <= '0;
         end else begin
            cnt <= cnt + ONE;
         end
      end else if (go && (width != '0)) begin
         q     <= 1'b1;
         qn    <= 1'b0;
         cnt   <= ONE;
         lat_w <= width;
      end
   end

endmodule

// File: rtl/oneshot_pulser.sv
module oneshot_pulser
   import oneshot_pkg::*;
#(
   parameter int WIDTH_W      = 8,
   parameter int SYNC_STAGES  = 2,
   parameter bit CLEAR_STARTS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trig_fall_n,
   input  logic               trig_rise,
   input  logic               clear_n,
   input  logic [WIDTH_W-1:0] width,
   output logic               pulse_q,
   output logic               pulse_qn
);

   localparam int LVL_W = $bits(lvl_t);

   generate
      if (WIDTH_W < 1) begin : g_bad_width
         $error("oneshot_pulser: WIDTH_W must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("oneshot_pulser: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [LVL_W-1:0]   raw_lvl, sync_lvl;
   lvl_t               lvl_s;
   logic               clr_s;
   logic               go;
   logic               q_i, qn_i;
   logic [WIDTH_W-1:0] cnt, lat_w;

   assign raw_lvl = {clear_n, trig_rise, trig_fall_n};

   oneshot_sync #(
      .N       (LVL_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (LVL_QUIET)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_lvl),
      .q     (sync_lvl)
   );

   assign lvl_s = lvl_t'(sync_lvl);
   assign clr_s = lvl_s.clr;

   oneshot_trig_gate #(
      .CLEAR_STARTS (CLEAR_STARTS)
   ) u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .cur   (lvl_s),
      .idle  (~q_i),
      .go    (go)
   );

   oneshot_timer #(
      .WIDTH_W (WIDTH_W)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_ok (clr_s),
      .go     (go),
      .width  (width),
      .q      (q_i),
      .qn     (qn_i),
      .cnt    (cnt),
      .lat_w  (lat_w)
   );

   assign pulse_q  = q_i;
   assign pulse_qn = qn_i;

endmodule

// File: rtl/oneshot_pulser_chk.sv
module oneshot_pulser_chk #(
   parameter int WIDTH_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pulse_q,
   input logic               pulse_qn,
   input logic               clr_s,
   input logic               go,
   input logic [WIDTH_W-1:0] width,
   input logic [WIDTH_W-1:0] cnt,
   input logic [WIDTH_W-1:0] lat_w
);

   assert_complement_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_qn == !pulse_q);

   assert_clear_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_s |=> !pulse_q);

   assert_width_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_q && $past(pulse_q)) |-> $stable(lat_w));

   assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> ((cnt != '0) && (cnt <= lat_w)));

   assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_q && $past(pulse_q)) |-> (cnt == $past(cnt) + 1'b1));

   assert_zero_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (go && (width == '0) && !pulse_q) |=> !pulse_q);

   assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_q) |-> ($past(go) && (cnt == 1)));

endmodule

bind oneshot_pulser oneshot_pulser_chk #(.WIDTH_W(WIDTH_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pulse_q  (pulse_q),
   .pulse_qn (pulse_qn),
   .clr_s    (clr_s),
   .go       (go),
   .width    (width),
   .cnt      (cnt),
   .lat_w    (lat_w)
);

// File: tb/oneshot_pulser_bench.sv
module oneshot_pulser_bench;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         a_drv = 1'b1;
   logic         b_drv = 1'b0;
   logic         c_drv = 1'b1;
   logic [W-1:0] w_drv = 8'd5;
   logic         pulse_q, pulse_qn;

   int n_checks = 0;
   int n_fail   = 0;
   string cur_req = "R1";

   always #2 clk = ~clk;

   oneshot_pulser #(.WIDTH_W(W)) u_oneshot_pulser (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig_fall_n (a_drv),
      .trig_rise   (b_drv),
      .clear_n     (c_drv),
      .width       (w_drv),
      .pulse_q     (pulse_q),
      .pulse_qn    (pulse_qn)
   );

   // ---------------- cycle model built from the requirements ----------------
   bit m1a, m1b, m1c, sa, sb, sc, pa, pb, pc, seen, busy;
   int cnt_m, lw_m;

   function automatic bit model_go(bit fa, bit rb, bit rc);
      return !busy && sc && ((fa && sb) || (rb && !sa) || (rc && !sa && sb && seen));
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m1a = 0; m1b = 1; m1c = 0; sa = 0; sb = 1; sc = 0;
         pa = 0; pb = 1; pc = 0; seen = 0; busy = 0; cnt_m = 0; lw_m = 0;
      end else begin
         bit fa, rb, rc, g, nseen;
         fa = pa && !sa;
         rb = !pb && sb;
         rc = !pc && sc;
         g  = model_go(fa, rb, rc);
         nseen = sc ? 1'b0 : (seen || sa || !sb);
         if (!sc) busy = 0;
         else if (busy) begin
            if (cnt_m == lw_m) busy = 0;
            else cnt_m++;
         end else if (g && (w_drv != 0)) begin
            busy = 1; cnt_m = 1; lw_m = int'(w_drv);
         end
         seen = nseen;
         pa = sa; pb = sb; pc = sc;
         sa = m1a; sb = m1b; sc = m1c;
         m1a = a_drv; m1b = b_drv; m1c = c_drv;
      end
   end

   // ---------------- checking helpers ----------------
   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // advance to the next falling edge and compare outputs against the model
   task automatic tick();
      @(negedge clk);
      chk(pulse_q == busy, cur_req, int'(pulse_q), int'(busy));
      chk(pulse_qn == !pulse_q, "R10", int'(pulse_qn), int'(!pulse_q));
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   // count high cycles of pulse_q over a window
   task automatic measure(input int n, input int exp, input string req);
      int hi = 0;
      for (int i = 0; i < n; i++) begin
         tick();
         if (pulse_q) hi++;
      end
      chk(hi == exp, req, hi, exp);
   endtask

   task automatic summary();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      #(760000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0221));
      // reset
      cur_req = "R1";
      run(4);
      rst_n = 1'b1;
      for (int i = 0; i < 6; i++) begin
         tick();
         chk(pulse_q == 1'b0 && pulse_qn == 1'b1, "R1", int'(pulse_q), 0);
      end

      // R2: fall on trig_fall_n with trig_rise high, exact latency
      cur_req = "R2";
      b_drv = 1; run(6);
      a_drv = 0;
      tick(); tick();
      chk(pulse_q == 1'b0, "R2", int'(pulse_q), 0);
      tick();
      chk(pulse_q == 1'b1, "R2", int'(pulse_q), 1);
      measure(11, 4, "R2");

      // R3: rise on trig_rise with trig_fall_n low
      cur_req = "R3";
      b_drv = 0; run(6);
      b_drv = 1;
      measure(14, 5, "R3");

      // R4: disabling levels block the other input
      cur_req = "R4";
      a_drv = 1; run(4);
      begin
         int hi = 0;
         for (int i = 0; i < 8; i++) begin
            b_drv = ~b_drv; tick(); if (pulse_q) hi++; tick(); if (pulse_q) hi++;
         end
         b_drv = 0; run(2);
         for (int i = 0; i < 8; i++) begin
            a_drv = ~a_drv; tick(); if (pulse_q) hi++; tick(); if (pulse_q) hi++;
         end
         run(4); if (pulse_q) hi++;
         chk(hi == 0, "R4", hi, 0);
      end

      // R5: width captured at the trigger, changes ignored, 1 and max
      cur_req = "R5";
      a_drv = 1; b_drv = 1; w_drv = 6; run(4);
      a_drv = 0; run(4); w_drv = 2;
      measure(12, 4, "R5");
      a_drv = 1; w_drv = 1; run(4); a_drv = 0;
      measure(8, 1, "R5");
      a_drv = 1; w_drv = 8'd255; run(4); a_drv = 0;
      measure(270, 255, "R5");

      // R6: edges during the pulse and in its last cycle are ignored
      cur_req = "R6";
      a_drv = 1; w_drv = 8; run(4);
      a_drv = 0; tick();
      begin
         int hi = 0;
         for (int i = 1; i <= 8; i++) begin
            a_drv = (i % 2 == 1);
            tick(); if (pulse_q) hi++;
         end
         for (int i = 0; i < 12; i++) begin tick(); if (pulse_q) hi++; end
         chk(hi == 8, "R6", hi, 8);
      end

      // R7: clear cuts the pulse and blocks triggers while low
      cur_req = "R7";
      a_drv = 1; w_drv = 10; run(4);
      a_drv = 0; run(5);
      c_drv = 0;
      measure(12, 2, "R7");
      begin
         int hi = 0;
         for (int i = 0; i < 6; i++) begin
            a_drv = 1; b_drv = 1; tick(); tick(); a_drv = 0; tick(); tick();
            b_drv = 0; tick(); b_drv = 1; tick();
            if (pulse_q) hi++;
         end
         chk(hi == 0, "R7", hi, 0);
      end

      // R8: clear release as a trigger after disarm then arm
      cur_req = "R8";
      a_drv = 1; b_drv = 0; w_drv = 7; run(4);
      a_drv = 0; b_drv = 1; run(4);
      c_drv = 1;
      measure(14, 7, "R8");
      c_drv = 0; run(8);
      c_drv = 1;
      measure(14, 0, "R8");

      // R9: zero width
      cur_req = "R9";
      w_drv = 0; a_drv = 1; run(4); a_drv = 0;
      measure(10, 0, "R9");
      b_drv = 0; run(4); b_drv = 1;
      measure(10, 0, "R9");

      // random phase against the model
      cur_req = "R2/R3/R6/R7/R8 random";
      for (int k = 0; k < 700; k++) begin
         a_drv = 1'($urandom_range(0, 1));
         b_drv = 1'($urandom_range(0, 1));
         c_drv = ($urandom_range(0, 7) != 0);
         w_drv = W'($urandom_range(0, 12));
         run(int'($urandom_range(1, 8)));
      end
      c_drv = 1; run(20);

      summary();
      $finish;
   end

endmodule